// File: doc/BRIEF.md
# Platform-Level Interrupt Router

This block collects a set of external interrupt sources and delivers them to several execution contexts. A context is one privilege level of one hardware thread, so a single hart may own more than one context (for example a machine-level and a supervisor-level one). Every source carries a programmable priority. Every context has its own enable mask over the sources and its own priority threshold. For each context the block continuously selects the best eligible pending source and raises that context's interrupt line while one exists.

Software in a context takes ownership of an interrupt by reading that context's claim register, which returns the winning source ID and atomically retires its pending state. After servicing, it writes the same ID back to the claim register to complete the interrupt. Between the claim and the completion the source's gateway accepts no new request. Each source is built as either level-sensitive or rising-edge-sensitive, chosen per source by a parameter mask.

Configuration and the claim/complete handshake use a flat register port with separate read and write strobes. Read data is combinational and valid in the same cycle as the read strobe. A claim takes effect at the clock edge that ends the read cycle.

Top module: `irq_fabric`

## Requirements
- R1: A source is presented to a context only when the bit for that source is set in the context's enable mask. Enable bit k (k ≥ 1) belongs to source k.
- R2: Among a context's eligible sources, the one with the numerically highest priority wins. Equal priorities go to the lowest source ID.
- R3: A source is eligible for a context only when its priority is strictly greater than the context's threshold. A priority of 0 therefore never interrupts, and a source left pending is presented as soon as its priority is raised above the threshold.
- R4: A claim read returns the current winning ID for that context, or 0 when there is none, and clears the returned source's pending state at the end of the read cycle.
- R5: A claimed source is not presented to any context again until a completion write carrying its ID arrives. Completion values of 0 or above the source count have no effect.
- R6: A level source becomes pending whenever its input is high and it is neither pending nor claimed. After completion it is pending again one cycle later if the input is still high, and not if the input is low.
- R7: An edge source latches exactly one pending event per rising edge. Rises that arrive while it is already pending or claimed are dropped, and an input that stays high produces no further event.
- R8: The register address is {kind[1:0], index}, with kind in the two top bits. Kind 0 is source priority (index = source ID; index 0 always reads 0). Kind 1 is a context enable mask, where bit 0 always reads 0. Kind 2 is a context threshold. Kind 3 is the context claim (read) or complete (write, data = source ID).
- R9: After reset all priorities, enables and thresholds are 0, nothing is pending or claimed, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt inputs; bit k-1 is source ID k |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a claim when kind is 3) |
| addr_i | input | IDX_W+2 | Register address {kind, index} |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rd_en_i is high |
| irq_o | output | NCTX | Per-context interrupt line |

## Verification
The bench builds the block with six sources, two contexts and 3-bit priorities. Sources 1 to 3 are level-sensitive and sources 4 to 6 are edge-sensitive. This configuration allows equal-priority ties, a threshold equal to a source's priority, and a source enabled on one context but not the other. It also puts both gateway kinds side by side, so the re-raise of a held level input and the dropped rise of a busy edge source can both be observed. Completion IDs of 0 and of one above the source count exercise the range check at the top of the ID space.

// File: rtl/irq_fabric_pkg.sv
package irq_fabric_pkg;
  typedef enum logic [1:0] {
    KIND_PRIO  = 2'd0,
    KIND_EN    = 2'd1,
    KIND_THR   = 2'd2,
    KIND_CLAIM = 2'd3
  } reg_kind_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic busy_o
);
  logic prev_q;
  logic trig;

  // Request qualifier picked by the gateway kind
  generate
    if (EDGE) begin : g_edge
      assign trig = req_i & ~prev_q;
    end else begin : g_level
      assign trig = req_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      prev_q <= req_i;
      if (claim_i) begin
        pend_o <= 1'b0;
        busy_o <= 1'b1;
      end else begin
        if (complete_i) busy_o <= 1'b0;
        if (trig && !busy_o && !pend_o) pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_target_arb.sv
module irq_target_arb #(
  parameter int NSRC = 10,
  parameter int PW   = 3,
  parameter int IW   = 4
) (
  input  logic [NSRC:0]         pend_i,
  input  logic [NSRC:0]         en_i,
  input  logic [NSRC:0][PW-1:0] prio_i,
  input  logic [PW-1:0]         thr_i,
  output logic [IW-1:0]         id_o,
  output logic                  irq_o
);
  // Strictly-greater scan: the first (lowest) ID keeps a tie
  function automatic logic [IW-1:0] pick_winner(
    input logic [NSRC:0]         pend,
    input logic [NSRC:0]         en,
    input logic [NSRC:0][PW-1:0] prio,
    input logic [PW-1:0]         thr
  );
    logic [IW-1:0] best_id;
    logic [PW-1:0] best_p;
    best_id = '0;
    best_p  = thr;
    for (int s = 1; s <= NSRC; s++) begin
      if (pend[s] && en[s] && prio[s] > best_p) begin
        best_p  = prio[s];
        best_id = IW'(s);
      end
    end
    return best_id;
  endfunction

  assign id_o  = pick_winner(pend_i, en_i, prio_i, thr_i);
  assign irq_o = (id_o != '0);
endmodule

// File: rtl/irq_fabric.sv
module irq_fabric
  import irq_fabric_pkg::*;
#(
  parameter int             NSRC      = 10,
  parameter int             NCTX      = 9,
  parameter int             PW        = 3,
  parameter logic [NSRC-1:0] EDGE_MASK = '0,
  localparam int IW     = $clog2(NSRC + 1),
  localparam int IDX_W  = $clog2(imax(NSRC + 1, NCTX)),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCTX-1:0]   irq_o
);
  logic [NSRC:0][PW-1:0]   prio_q;
  logic [NCTX-1:0][NSRC:0] en_q;
  logic [NCTX-1:0][PW-1:0] thr_q;

  // Named internal events for the checker
  logic [NSRC:0]           pend_vec;
  logic [NSRC:0]           busy_vec;
  logic [NCTX-1:0][IW-1:0] ctx_id;
  logic                    claim_fire;
  logic [IW-1:0]           claim_src;
  logic                    cmpl_fire;
  logic [IW-1:0]           cmpl_src;

  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             idx_is_src;
  logic             idx_is_ctx;

  assign kind       = reg_kind_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx        = addr_i[IDX_W-1:0];
  assign idx_is_src = (idx != '0) && (idx <= IDX_W'(NSRC));
  assign idx_is_ctx = (idx < IDX_W'(NCTX));

  assign claim_fire = rd_en_i && kind == KIND_CLAIM && idx_is_ctx;
  assign claim_src  = idx_is_ctx ? ctx_id[idx] : '0;
  assign cmpl_fire  = wr_en_i && kind == KIND_CLAIM && idx_is_ctx &&
                      wdata_i != 32'd0 && wdata_i <= 32'(NSRC);
  assign cmpl_src   = wdata_i[IW-1:0];

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_en_i) begin
      unique case (kind)
        KIND_PRIO: if (idx_is_src) prio_q[idx] <= wdata_i[PW-1:0];
        KIND_EN:   if (idx_is_ctx) en_q[idx] <= {wdata_i[NSRC:1], 1'b0};
        KIND_THR:  if (idx_is_ctx) thr_q[idx] <= wdata_i[PW-1:0];
        default: ;
      endcase
    end
  end

  // One gateway per source
  assign pend_vec[0] = 1'b0;
  assign busy_vec[0] = 1'b0;
  generate
    for (genvar s = 1; s <= NSRC; s++) begin : g_src
      irq_gateway #(.EDGE(EDGE_MASK[s-1])) u_gw (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (src_i[s-1]),
        .claim_i   (claim_fire && claim_src == IW'(s)),
        .complete_i(cmpl_fire && cmpl_src == IW'(s)),
        .pend_o    (pend_vec[s]),
        .busy_o    (busy_vec[s])
      );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      irq_target_arb #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
        .pend_i(pend_vec),
        .en_i  (en_q[c]),
        .prio_i(prio_q),
        .thr_i (thr_q[c]),
        .id_o  (ctx_id[c]),
        .irq_o (irq_o[c])
      );
    end
  endgenerate

  // Combinational read mux
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (kind)
        KIND_PRIO:  if (idx_is_src) rdata_o = 32'(prio_q[idx]);
        KIND_EN:    if (idx_is_ctx) rdata_o = 32'(en_q[idx]);
        KIND_THR:   if (idx_is_ctx) rdata_o = 32'(thr_q[idx]);
        KIND_CLAIM: rdata_o = 32'(claim_src);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_fabric_checker.sv
module irq_fabric_checker #(
  parameter int NSRC = 10,
  parameter int NCTX = 9,
  parameter int PW   = 3,
  parameter int IW   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSRC:0]           pend_vec,
  input logic [NSRC:0]           busy_vec,
  input logic [NCTX-1:0][IW-1:0] ctx_id,
  input logic [NSRC:0][PW-1:0]   prio_q,
  input logic [NCTX-1:0][NSRC:0] en_q,
  input logic [NCTX-1:0][PW-1:0] thr_q,
  input logic [NCTX-1:0]         irq_o,
  input logic                    claim_fire,
  input logic [IW-1:0]           claim_src,
  input logic                    cmpl_fire,
  input logic [IW-1:0]           cmpl_src
);
  assert_busy_not_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & busy_vec) == '0);

  assert_claim_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && claim_src != '0) |=> busy_vec[$past(claim_src)] && !pend_vec[$past(claim_src)]);

  assert_complete_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_fire && !claim_fire && busy_vec[cmpl_src]) |=> !busy_vec[$past(cmpl_src)]);

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_c
      assert_irq_above_threshold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> prio_q[ctx_id[c]] > thr_q[c]);

      assert_winner_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> en_q[c][ctx_id[c]] && pend_vec[ctx_id[c]]);

      assert_claimed_not_presented_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> !busy_vec[ctx_id[c]]);
    end
  endgenerate
endmodule

bind irq_fabric irq_fabric_checker #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_vec  (pend_vec),
  .busy_vec  (busy_vec),
  .ctx_id    (ctx_id),
  .prio_q    (prio_q),
  .en_q      (en_q),
  .thr_q     (thr_q),
  .irq_o     (irq_o),
  .claim_fire(claim_fire),
  .claim_src (claim_src),
  .cmpl_fire (cmpl_fire),
  .cmpl_src  (cmpl_src)
);

// File: tb/irq_fabric_test.sv
module irq_fabric_test;
  localparam int NSRC   = 6;
  localparam int NCTX   = 2;
  localparam int PW     = 3;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = IDX_W + 2;
  localparam logic [1:0] K_PRIO = 2'd0, K_EN = 2'd1, K_THR = 2'd2, K_CLM = 2'd3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   src = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCTX-1:0]   irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_fabric #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .EDGE_MASK(6'b111000)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input int i, input logic [31:0] d);
    @(negedge clk);
    addr = {k, IDX_W'(i)}; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] k, input int i, output logic [31:0] d);
    @(negedge clk);
    addr = {k, IDX_W'(i)}; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic claim_expect(input string req, input int ctx, input int exp);
    logic [31:0] d;
    rd(K_CLM, ctx, d);
    check(req, d, 32'(exp));
  endtask

  task automatic set_src(input int id, input logic v);
    @(negedge clk);
    src[id-1] = v;
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    check("R9 irq after reset", 32'(irq), 0);
    rd(K_PRIO, 1, d);
    check("R9 priority after reset", d, 0);
    claim_expect("R9 claim after reset", 0, 0);
  endtask

  task automatic test_priority_and_ties();
    wr(K_PRIO, 1, 2); wr(K_PRIO, 2, 5); wr(K_PRIO, 3, 5);
    wr(K_EN, 0, 32'b1110);
    wr(K_THR, 0, 0); wr(K_THR, 1, 0);
    @(negedge clk); src[2:0] = 3'b111;
    @(negedge clk);
    @(negedge clk);
    check("R2 irq0 raised", 32'(irq[0]), 1);
    check("R1 irq1 stays low without enables", 32'(irq[1]), 0);
    claim_expect("R1 claim on ctx1 without enables", 1, 0);
    claim_expect("R2 tie goes to lowest ID", 0, 2);
    claim_expect("R2 next equal priority", 0, 3);
    claim_expect("R2 lower priority last", 0, 1);
    claim_expect("R4 nothing eligible returns 0", 0, 0);
    check("R5 irq0 low while all claimed", 32'(irq[0]), 0);
    wr(K_CLM, 0, 2);
    claim_expect("R6 level re-raises after complete", 0, 2);
    @(negedge clk); src[2:0] = 3'b000;
    wr(K_CLM, 0, 1); wr(K_CLM, 0, 2); wr(K_CLM, 0, 3);
    @(negedge clk);
    claim_expect("R6 no re-raise when input low", 0, 0);
  endtask

  task automatic test_threshold();
    wr(K_THR, 0, 5);
    set_src(2, 1'b1);
    @(negedge clk);
    check("R3 priority equal to threshold masked", 32'(irq[0]), 0);
    claim_expect("R3 claim while masked", 0, 0);
    wr(K_THR, 0, 4);
    check("R3 priority above threshold presented", 32'(irq[0]), 1);
    claim_expect("R3 claim above threshold", 0, 2);
    @(negedge clk); src[1] = 1'b0;
    wr(K_CLM, 0, 2);
    wr(K_THR, 0, 0);
  endtask

  task automatic test_enable_split();
    wr(K_EN, 1, 32'b0010);
    set_src(1, 1'b1);
    check("R1 ctx1 sees enabled source", 32'(irq[1]), 1);
    claim_expect("R1 ctx1 claims source 1", 1, 1);
    check("R5 ctx0 not offered claimed source", 32'(irq[0]), 0);
    wr(K_CLM, 1, 0);
    wr(K_CLM, 1, NSRC + 1);
    @(negedge clk);
    check("R5 out-of-range completion ignored", 32'(irq), 0);
    @(negedge clk); src[0] = 1'b0;
    wr(K_CLM, 1, 1);
    @(negedge clk);
    check("R6 released low source idle", 32'(irq), 0);
    wr(K_EN, 1, 0);
  endtask

  task automatic test_prio_zero();
    wr(K_EN, 1, 32'b100000);
    set_src(5, 1'b1);
    set_src(5, 1'b0);
    check("R3 priority 0 never interrupts", 32'(irq[1]), 0);
    wr(K_PRIO, 5, 1);
    check("R3 held pending presented once priority raised", 32'(irq[1]), 1);
    claim_expect("R3 claim raised source", 1, 5);
    wr(K_CLM, 1, 5);
  endtask

  task automatic test_edge();
    wr(K_PRIO, 4, 3);
    wr(K_EN, 1, 32'b10000);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    claim_expect("R7 edge pending latched", 1, 4);
    claim_expect("R7 two rises give one event", 1, 0);
    set_src(4, 1'b1);
    set_src(4, 1'b0);
    wr(K_CLM, 1, 4);
    @(negedge clk);
    claim_expect("R7 rise while claimed dropped", 1, 0);
    set_src(4, 1'b1);
    claim_expect("R7 new rise after completion", 1, 4);
    wr(K_CLM, 1, 4);
    @(negedge clk); @(negedge clk);
    claim_expect("R7 held high gives no new event", 1, 0);
    @(negedge clk); src[3] = 1'b0;
  endtask

  task automatic test_reg_map();
    logic [31:0] d;
    wr(K_PRIO, 0, 7);
    rd(K_PRIO, 0, d);
    check("R8 priority index 0 reads 0", d, 0);
    rd(K_PRIO, 2, d);
    check("R8 priority readback", d, 5);
    wr(K_EN, 0, 32'hFFFF_FFFF);
    rd(K_EN, 0, d);
    check("R8 enable bit 0 reads 0", d, 32'b1111110);
    wr(K_THR, 1, 6);
    rd(K_THR, 1, d);
    check("R8 threshold readback", d, 6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_priority_and_ties();
    test_threshold();
    test_enable_split();
    test_prio_zero();
    test_edge();
    test_reg_map();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule